// File: doc/BRIEF.md
# Cache Tag Store with Equality Compare

This block holds one narrow slice of a cache tag directory: a small memory of short tag words, and next to it a comparator that checks the word at the current address against the tag the processor presents. On each clock edge the block samples the address, the data input and three active-low controls. It then does one of four things: a match, a write, a read, or a clear of the whole array. The compare result appears one clock later on a registered match flag.

A wide tag is built from several slices. Each slice compares its own bits. A cascade input is ANDed into each slice's result, so the slices can be chained into one hit signal.

Clearing the array takes a single cycle. Each entry has a valid bit, and all of these bits are dropped together. An entry that has not been written since the last clear or reset reads as all zeros and compares as a stored zero. The data path uses separate input and output ports. A flag marks the cycles in which the output carries a read result.

Top module: `tag_cmp_store`

## Requirements
- R1: After reset, match, dataOutValid and dataOut are all 0, and every entry reads as 0000.
- R2: In a match cycle (weN=1, oeN=1, clrN=1), match is 1 one clock later when the word stored at addr equals dataIn and matchIn is 1.
- R3: In a match cycle whose stored word differs from dataIn, match is 0 one clock later.
- R4: A write cycle (weN=0, clrN=1) stores dataIn at addr whatever oeN is. Match is 0 one clock later. A match cycle in the very next clock already sees the new word.
- R5: A read cycle (weN=1, oeN=0, clrN=1) gives, one clock later, the word at addr on dataOut with dataOutValid=1 and match=0.
- R6: After any cycle that is not a read, dataOutValid is 0 and dataOut is 0000.
- R7: A clear cycle (clrN=0) sets every entry to 0000 whatever weN and oeN are. No write takes place in that cycle, and match is 0 one clock later.
- R8: When matchIn is 0 in a match cycle, match is 0 one clock later even if the words are equal.
- R9: One compare completes per clock. Back-to-back match cycles at different addresses each give their own result in consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Entry address |
| dataIn | input | 4 | Tag to write or compare |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| clrN | input | 1 | Clear-all, active low, highest priority |
| matchIn | input | 1 | Cascade hit from the preceding slice |
| match | output | 1 | Registered hit, cascade included |
| dataOut | output | 4 | Read word |
| dataOutValid | output | 1 | dataOut carries a read result |

## Verification
Compares are tried with equal words, with unequal words and with equal words while the cascade is low. Together these separate a correct AND from a comparator that ignores one of its inputs. Alternating compares at the lowest and highest address show that each result belongs to its own clock and address. A compare placed directly after a write shows that a new word is visible at once. Finally, a clear issued with write enable also asserted is followed by a read and by a compare against zero. These show that clear wins over write and that cleared entries behave as stored zeros.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  typedef enum logic [1:0] {
    MODE_MATCH,
    MODE_WRITE,
    MODE_READ,
    MODE_CLEAR
  } tagMode_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic cmpEn;
    logic clrAll;
  } tagStrobe_t;
endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_store_pkg::*;
(
  input  logic       weN,
  input  logic       oeN,
  input  logic       clrN,
  output tagStrobe_t strb
);
  tagMode_e mode;

  // clear outranks write, write outranks read
  always_comb begin
    if (!clrN)      mode = MODE_CLEAR;
    else if (!weN)  mode = MODE_WRITE;
    else if (!oeN)  mode = MODE_READ;
    else            mode = MODE_MATCH;
  end

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_CLEAR: strb.clrAll = 1'b1;
      MODE_WRITE: strb.wrEn   = 1'b1;
      MODE_READ:  strb.rdEn   = 1'b1;
      default:    strb.cmpEn  = 1'b1;
    endcase
  end
endmodule

// File: rtl/tag_dp.sv
module tag_dp
  import tag_store_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              matchIn,
  output logic              match,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  validQ;
  logic [DATA_W-1:0] storedWord;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[addr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= '0;
    else if (strb.clrAll) validQ <= '0;
    else if (strb.wrEn)   validQ[addr] <= 1'b1;
  end

  assign storedWord = validQ[addr] ? mem[addr] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      match        <= 1'b0;
      dataOut      <= '0;
      dataOutValid <= 1'b0;
    end else begin
      match        <= strb.cmpEn && matchIn && (storedWord == dataIn);
      dataOut      <= strb.rdEn ? storedWord : '0;
      dataOutValid <= strb.rdEn;
    end
  end
endmodule

// File: rtl/tag_cmp_store.sv
module tag_cmp_store
  import tag_store_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              weN,
  input  logic              oeN,
  input  logic              clrN,
  input  logic              matchIn,
  output logic              match,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutValid
);
  tagStrobe_t strb;

  tag_ctrl ctrl_i (
    .weN (weN),
    .oeN (oeN),
    .clrN(clrN),
    .strb(strb)
  );

  tag_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .addr        (addr),
    .dataIn      (dataIn),
    .matchIn     (matchIn),
    .match       (match),
    .dataOut     (dataOut),
    .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/tag_cmp_store_chk.sv
module tag_cmp_store_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              weN,
  input logic              oeN,
  input logic              clrN,
  input logic              matchIn,
  input logic              match,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutValid
);
  assert_write_no_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && clrN) |=> !match);

  assert_read_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && weN && !oeN) |=> (dataOutValid && !match));

  assert_idle_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(clrN && weN && !oeN) |=> (!dataOutValid && dataOut == '0));

  assert_clear_no_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> !match);

  assert_cascade_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !matchIn |=> !match);
endmodule

bind tag_cmp_store tag_cmp_store_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .weN         (weN),
  .oeN         (oeN),
  .clrN        (clrN),
  .matchIn     (matchIn),
  .match       (match),
  .dataOut     (dataOut),
  .dataOutValid(dataOutValid)
);

// File: tb/tag_cmp_store_tb.sv
module tag_cmp_store_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic       weN = 1'b1, oeN = 1'b1, clrN = 1'b1, matchIn = 1'b1;
  logic       match;
  logic [3:0] dataOut;
  logic       dataOutValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  tag_cmp_store dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .weN(weN), .oeN(oeN), .clrN(clrN), .matchIn(matchIn),
    .match(match), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one cycle, wait for the edge, settle
  task automatic step(input bit w, input bit o, input bit c,
                      input logic [11:0] a, input logic [3:0] d, input bit mi);
    weN = w; oeN = o; clrN = c; addr = a; dataIn = d; matchIn = mi;
    @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [3:0] d, input bit o);
    step(1'b0, o, 1'b1, a, d, 1'b1);
    check(match == 1'b0, "R4 write no match", match, 0);
  endtask

  task automatic doMatch(input logic [11:0] a, input logic [3:0] d, input bit mi,
                         input bit exp, input string req);
    step(1'b1, 1'b1, 1'b1, a, d, mi);
    check(match == exp, req, match, exp);
    check(!dataOutValid && dataOut == 4'h0, "R6 idle out", dataOut, 0);
  endtask

  task automatic doRead(input logic [11:0] a, input logic [3:0] exp, input string req);
    step(1'b1, 1'b0, 1'b1, a, 4'h0, 1'b1);
    check(dataOutValid && dataOut == exp, req, dataOut, exp);
    check(match == 1'b0, "R5 read no match", match, 0);
  endtask

  task automatic testReset();
    check(match == 0 && dataOutValid == 0 && dataOut == 0, "R1 reset outputs",
          {match, dataOutValid, dataOut}, 0);
    doRead(12'h005, 4'h0, "R1 entry reads zero");
  endtask

  task automatic testWriteMatch();
    doWrite(12'h123, 4'hA, 1'b0);      // R4: oeN low ignored
    doMatch(12'h123, 4'hA, 1'b1, 1'b1, "R2 equal hit");
    doMatch(12'h123, 4'h5, 1'b1, 1'b0, "R3 unequal miss");
    doRead(12'h123, 4'hA, "R5 read word");
  endtask

  task automatic testBackToBack();
    doWrite(12'hFFF, 4'h3, 1'b1);
    doWrite(12'h000, 4'hC, 1'b1);
    doMatch(12'hFFF, 4'h3, 1'b1, 1'b1, "R9 hit top");
    doMatch(12'h000, 4'h3, 1'b1, 1'b0, "R9 miss bottom");
    doMatch(12'h000, 4'hC, 1'b1, 1'b1, "R9 hit bottom");
    doMatch(12'hFFF, 4'hC, 1'b1, 1'b0, "R9 miss top");
    doWrite(12'h010, 4'h7, 1'b1);
    doMatch(12'h010, 4'h7, 1'b1, 1'b1, "R4 new word seen next cycle");
  endtask

  task automatic testCascade();
    doMatch(12'h123, 4'hA, 1'b0, 1'b0, "R8 cascade low");
    doMatch(12'h123, 4'hA, 1'b1, 1'b1, "R8 cascade high");
  endtask

  task automatic testClear();
    step(1'b0, 1'b0, 1'b0, 12'h123, 4'h9, 1'b1);
    check(match == 0 && !dataOutValid, "R7 clear outputs", match, 0);
    doRead(12'h123, 4'h0, "R7 cleared no write");
    doMatch(12'hFFF, 4'h0, 1'b1, 1'b1, "R7 cleared compares zero");
    doMatch(12'h000, 4'hC, 1'b1, 1'b0, "R7 old word gone");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    testReset();
    testWriteMatch();
    testBackToBack();
    testCascade();
    testClear();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule